// File: doc/BRIEF.md
# Stateful Two-Master Memory Access Guard

This block stands between two bus masters and one shared memory bus and rules on every access. A round-robin arbiter accepts at most one request per cycle. The accepted request carries a master number, a 2-bit operation and a 32-bit byte address. The address is compared with every configured inclusive range at once, which gives one match bit per range. A policy state machine then looks at the master, the operation and the match vector together. It grants or denies the access and may change its own state.

The state machine has four states. In `ST_BASE`, each master may use its own memory half, its own I/O window and the shared debug window. A write by master m to the "take" control word moves the machine to ownership state `ST_OWN0` or `ST_OWN1` (transition TAKE). In an ownership state the owner additionally gets read/write access to the crypto window and the key control word. A write by the owner to the "release" control word returns the machine to `ST_BASE` (transition RELEASE). Any access that is not legal in the current state causes transition VIOLATE into `ST_REJECT`. That state is held until synchronous reset (transition RESET). In it every request is denied and the violation flag stays high.

The ranges, by match index, are:
- 0, debug: 0x41400000–0x4140FFFF
- 1, crypto window: 0x28000000–0x28000FFF
- 2, memory half A: 0x24000000–0x247FFFFF
- 3, memory half B: 0x24800000–0x24FFFFFF
- 4, serial I/O: 0x40600000–0x4060FFFF
- 5, network I/O: 0x40C00000–0x40C0FFFF
- 6, take word: 0x28000004–0x28000007
- 7, release word: 0x28000008–0x2800000F
- 8, key control: 0x28000000–0x28000003

Ranges 6, 7 and 8 lie inside range 1.

Top module: `mem_guard_monitor`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the machine is in `ST_BASE`, `resp_valid` is 0, `violation` is 0, and the arbiter favours master 0.
- R2: A master raising `req_valid` alone sees its `req_ready` bit high in that same cycle and is accepted at the next edge; `req_ready` is never high for both masters.
- R3: When both masters request in one cycle, the favoured master is accepted and favour then passes to the other master, so held simultaneous requests alternate 0, 1, 0.
- R4: One cycle after an accept, `resp_valid` is high for exactly one cycle, with `resp_id` equal to the accepted master and `resp_grant` giving the verdict.
- R5: In `ST_BASE` master 0 may read (op 01) or write (op 10) ranges 0, 2 and 4, and master 1 may read or write ranges 0, 3 and 5.
- R6: Range bounds are inclusive: the low and high addresses of a range match, and the address one above the high bound does not.
- R7: TAKE: a write by master m to range 6 in `ST_BASE` is granted and moves to `ST_OWN<m>`. There the owner is granted ranges 1 and 8, and the other master's access to range 1 is denied.
- R8: RELEASE: a write by the owner to range 7 is granted and returns to `ST_BASE`, after which the crypto window is denied again. A write to range 7 by the non-owner is denied.
- R9: A read of the take word in `ST_BASE` is not a trigger and is denied.
- R10: Any denied access enters `ST_REJECT`. From the following cycle `violation` is 1 and every request by either master is denied until reset.
- R11: Operation codes 00 and 11 are illegal in every state and are denied.
- R12: Only the accepted request is judged. A request that is waiting while the other master is accepted does not change the state and does not raise `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 2 | Request valid, one bit per master |
| req_ready | output | 2 | Request accepted this cycle, one bit per master |
| req_op | input | 2x2 | Operation per master: 01 read, 10 write |
| req_addr | input | 2x32 | Byte address per master |
| resp_valid | output | 1 | Verdict valid (one cycle after accept) |
| resp_grant | output | 1 | 1 = access granted, 0 = denied |
| resp_id | output | 1 | Master that the verdict belongs to |
| violation | output | 1 | High while in the reject state |

## Verification
`req_ready` is combinational, so the bench samples it one nanosecond after driving a request, before the accepting edge. The verdict is registered once: `resp_valid`, `resp_grant` and `resp_id` are read one nanosecond after the accepting edge. `violation` follows the state register and is due at that same point. Each access task drives at a falling edge, checks `req_ready` before the rising edge, and checks the verdict just after it. The arbitration task holds both requests over three edges and checks the winner and the verdict of each edge in turn.

// File: rtl/mgm_pkg.sv
package mgm_pkg;
    localparam int ADDR_W     = 32;
    localparam int NUM_RANGES = 9;

    // Range indices the policy decodes
    localparam int RG_DEBUG  = 0;
    localparam int RG_CRYPTO = 1;
    localparam int RG_MEM_A  = 2;
    localparam int RG_MEM_B  = 3;
    localparam int RG_SERIAL = 4;
    localparam int RG_NET    = 5;
    localparam int RG_TAKE   = 6;
    localparam int RG_REL    = 7;
    localparam int RG_KEYCTL = 8;

    localparam logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_LO_DEF = {
        32'h2800_0000, 32'h2800_0008, 32'h2800_0004, 32'h40C0_0000,
        32'h4060_0000, 32'h2480_0000, 32'h2400_0000, 32'h2800_0000,
        32'h4140_0000};
    localparam logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_HI_DEF = {
        32'h2800_0003, 32'h2800_000F, 32'h2800_0007, 32'h40C0_FFFF,
        32'h4060_FFFF, 32'h24FF_FFFF, 32'h247F_FFFF, 32'h2800_0FFF,
        32'h4140_FFFF};

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_BOTH  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_BASE   = 2'd0,
        ST_OWN0   = 2'd1,
        ST_OWN1   = 2'd2,
        ST_REJECT = 2'd3
    } pstate_e;
endpackage

// File: rtl/mgm_rr_arbiter.sv
module mgm_rr_arbiter (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] valid_i,
    output logic [1:0] ready_o,
    output logic       sel_o,
    output logic       accept_o
);
    logic prio_q;

    always_comb begin
        sel_o      = (valid_i[0] && valid_i[1]) ? prio_q : valid_i[1];
        accept_o   = |valid_i;
        ready_o[0] = valid_i[0] && !sel_o;
        ready_o[1] = valid_i[1] && sel_o;
    end

    always_ff @(posedge clk) begin
        if (rst)           prio_q <= 1'b0;
        else if (accept_o) prio_q <= ~sel_o;
    end

    a_r2_single_ready: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ready_o));

    a_r3_alternate: assert property (@(posedge clk) disable iff (rst)
        (&valid_i) |=> (!(&valid_i) || (ready_o != $past(ready_o))));
endmodule

// File: rtl/mgm_range_match.sv
module mgm_range_match
    import mgm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_RANGES,
    parameter logic [NR-1:0][AW-1:0] LO = RANGE_LO_DEF,
    parameter logic [NR-1:0][AW-1:0] HI = RANGE_HI_DEF
) (
    input  logic [AW-1:0] addr_i,
    output logic [NR-1:0] hit_o
);
    for (genvar g = 0; g < NR; g++) begin : g_cmp
        assign hit_o[g] = (addr_i >= LO[g]) && (addr_i <= HI[g]);
    end
endmodule

// File: rtl/mgm_policy_fsm.sv
module mgm_policy_fsm
    import mgm_pkg::*;
#(
    parameter int NR = NUM_RANGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_i,
    input  logic          id_i,
    input  logic [1:0]    op_i,
    input  logic [NR-1:0] hit_i,
    output logic          resp_valid_o,
    output logic          resp_grant_o,
    output logic          resp_id_o,
    output logic          violation_o
);
    pstate_e state_q, state_d;
    logic    grant;

    function automatic logic [NR-1:0] allow_mask(pstate_e st, logic id);
        logic [NR-1:0] m;
        m = '0;
        m[RG_DEBUG] = 1'b1;
        if (!id) begin
            m[RG_MEM_A]  = 1'b1;
            m[RG_SERIAL] = 1'b1;
        end else begin
            m[RG_MEM_B]  = 1'b1;
            m[RG_NET]    = 1'b1;
        end
        if ((st == ST_OWN0 && !id) || (st == ST_OWN1 && id)) begin
            m[RG_CRYPTO] = 1'b1;
            m[RG_KEYCTL] = 1'b1;
        end
        if (st == ST_REJECT) m = '0;
        return m;
    endfunction

    logic op_ok, is_wr, in_set;
    always_comb begin
        op_ok  = (op_i == OP_READ) || (op_i == OP_WRITE);
        is_wr  = (op_i == OP_WRITE);
        in_set = op_ok && (|(hit_i & allow_mask(state_q, id_i)));
    end

    // next state and verdict
    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        unique case (state_q)
            ST_BASE: begin
                if (is_wr && hit_i[RG_TAKE]) begin
                    grant   = 1'b1;
                    state_d = id_i ? ST_OWN1 : ST_OWN0;
                end else begin
                    grant = in_set;
                end
            end
            ST_OWN0, ST_OWN1: begin
                grant = in_set;
                if (in_set && is_wr && hit_i[RG_REL]) state_d = ST_BASE;
            end
            ST_REJECT: grant = 1'b0;
        endcase
        if (!grant && state_q != ST_REJECT) state_d = ST_REJECT;
        if (!acc_i) state_d = state_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_BASE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid_o <= 1'b0;
            resp_grant_o <= 1'b0;
            resp_id_o    <= 1'b0;
        end else begin
            resp_valid_o <= acc_i;
            resp_grant_o <= acc_i && grant;
            if (acc_i) resp_id_o <= id_i;
        end
    end

    assign violation_o = (state_q == ST_REJECT);

    a_r10_reject_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REJECT) |=> (state_q == ST_REJECT));

    a_r12_idle_holds_state: assert property (@(posedge clk) disable iff (rst)
        !acc_i |=> $stable(state_q));

    a_r7_own_from_base: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BASE) |=> (state_q != ST_OWN0 || !$past(id_i)));
endmodule

// File: rtl/mem_guard_monitor.sv
module mem_guard_monitor
    import mgm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_RANGES,
    parameter logic [NR-1:0][AW-1:0] LO = RANGE_LO_DEF,
    parameter logic [NR-1:0][AW-1:0] HI = RANGE_HI_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          req_valid,
    output logic [1:0]          req_ready,
    input  logic [1:0][1:0]     req_op,
    input  logic [1:0][AW-1:0]  req_addr,
    output logic                resp_valid,
    output logic                resp_grant,
    output logic                resp_id,
    output logic                violation
);
    logic          sel, accept;
    logic [NR-1:0] hit;
    logic [AW-1:0] addr_m;
    logic [1:0]    op_m;

    mgm_rr_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (req_valid),
        .ready_o  (req_ready),
        .sel_o    (sel),
        .accept_o (accept)
    );

    assign addr_m = req_addr[sel];
    assign op_m   = req_op[sel];

    mgm_range_match #(.AW(AW), .NR(NR), .LO(LO), .HI(HI)) u_match (
        .addr_i (addr_m),
        .hit_o  (hit)
    );

    mgm_policy_fsm #(.NR(NR)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .acc_i        (accept),
        .id_i         (sel),
        .op_i         (op_m),
        .hit_i        (hit),
        .resp_valid_o (resp_valid),
        .resp_grant_o (resp_grant),
        .resp_id_o    (resp_id),
        .violation_o  (violation)
    );

    a_r4_resp_follows_accept: assert property (@(posedge clk) disable iff (rst)
        (|req_ready) |=> (resp_valid && resp_id == $past(req_ready[1])));

    a_r4_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !(|req_ready) |=> !resp_valid);

    a_r10_deny_latches: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_grant) |-> violation);
endmodule

// File: tb/mem_guard_monitor_bench.sv
module mem_guard_monitor_bench;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       req_valid = '0;
    logic [1:0]       req_ready;
    logic [1:0][1:0]  req_op = '0;
    logic [1:0][31:0] req_addr = '0;
    logic             resp_valid, resp_grant, resp_id, violation;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mem_guard_monitor u_mem_guard_monitor (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .resp_valid(resp_valid),
        .resp_grant(resp_grant), .resp_id(resp_id), .violation(violation)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = '0;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
        chk(violation == 1'b0, "R1 violation after reset", violation, 0);
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", resp_valid, 0);
    endtask

    task automatic access(input int m, input logic [1:0] op, input logic [31:0] addr,
                          input bit exp_g, input string tag);
        @(negedge clk);
        req_valid[m] = 1'b1;
        req_op[m]    = op;
        req_addr[m]  = addr;
        #1 chk(req_ready[m] == 1'b1, {"R2 ready ", tag}, req_ready, 2'b1 << m);
        @(posedge clk);
        #1 req_valid = '0;
        chk(resp_valid == 1'b1, {"R4 resp_valid ", tag}, resp_valid, 1);
        chk(resp_id == m[0], {"R4 resp_id ", tag}, resp_id, m);
        chk(resp_grant == exp_g, {tag, " grant"}, resp_grant, exp_g);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(req_ready == 2'b00, "R1 no ready when idle", req_ready, 0);
        chk(resp_valid == 1'b0, "R4 no response when idle", resp_valid, 0);
    endtask

    task automatic t_base_legal();
        do_reset();
        access(0, 2'b01, 32'h2400_0000, 1, "R6 mem A low bound");
        access(0, 2'b10, 32'h247F_FFFF, 1, "R6 mem A high bound");
        access(0, 2'b01, 32'h4060_0010, 1, "R5 m0 serial");
        access(0, 2'b10, 32'h4140_FFFF, 1, "R5 m0 debug");
        access(1, 2'b10, 32'h40C0_1234, 1, "R5 m1 network");
        access(1, 2'b01, 32'h2480_0000, 1, "R5 m1 mem B");
        access(1, 2'b01, 32'h4140_0000, 1, "R5 m1 debug");
        chk(violation == 1'b0, "R5 no violation", violation, 0);
    endtask

    task automatic t_reject_sticky();
        do_reset();
        access(0, 2'b01, 32'h2480_0000, 0, "R6 above mem A bound");
        chk(violation == 1'b1, "R10 violation set", violation, 1);
        access(0, 2'b01, 32'h4060_0000, 0, "R10 sticky m0");
        access(1, 2'b10, 32'h4140_0000, 0, "R10 sticky m1");
        chk(violation == 1'b1, "R10 violation held", violation, 1);
        do_reset();
        access(0, 2'b01, 32'h4060_0000, 1, "R1 grant after reset");
    endtask

    task automatic t_take();
        do_reset();
        access(0, 2'b10, 32'h2800_0004, 1, "R7 take by m0");
        access(0, 2'b01, 32'h2800_0100, 1, "R7 owner crypto read");
        access(0, 2'b10, 32'h2800_0000, 1, "R7 owner key write");
        chk(violation == 1'b0, "R7 no violation", violation, 0);
        access(1, 2'b01, 32'h2800_0100, 0, "R7 non-owner crypto");
        chk(violation == 1'b1, "R7 violation", violation, 1);
    endtask

    task automatic t_release();
        do_reset();
        access(1, 2'b10, 32'h2800_0007, 1, "R7 take by m1");
        access(1, 2'b10, 32'h2800_0008, 1, "R8 release by m1");
        access(1, 2'b01, 32'h2800_0100, 0, "R8 crypto after release");
        do_reset();
        access(1, 2'b10, 32'h2800_0004, 1, "R7 take by m1 again");
        access(0, 2'b10, 32'h2800_000C, 0, "R8 release by non-owner");
    endtask

    task automatic t_not_trigger();
        do_reset();
        access(0, 2'b01, 32'h2800_0004, 0, "R9 read of take word");
        chk(violation == 1'b1, "R9 violation", violation, 1);
    endtask

    task automatic t_bad_op();
        do_reset();
        access(0, 2'b11, 32'h4060_0000, 0, "R11 op 11");
        do_reset();
        access(1, 2'b00, 32'h40C0_0000, 0, "R11 op 00");
    endtask

    task automatic t_arbitration();
        do_reset();
        @(negedge clk);
        req_valid = 2'b11;
        req_op[0] = 2'b01; req_addr[0] = 32'h4060_0000;
        req_op[1] = 2'b10; req_addr[1] = 32'h4060_0000;
        #1 chk(req_ready == 2'b01, "R3 master 0 first", req_ready, 2'b01);
        @(posedge clk);
        #1 req_addr[1] = 32'h40C0_0000;
        chk(resp_valid && resp_id == 1'b0 && resp_grant, "R12 m0 verdict",
            {resp_valid, resp_id, resp_grant}, 3'b101);
        chk(violation == 1'b0, "R12 waiting request not judged", violation, 0);
        chk(req_ready == 2'b10, "R3 master 1 next", req_ready, 2'b10);
        @(posedge clk);
        #1 chk(resp_valid && resp_id == 1'b1 && resp_grant, "R3 m1 verdict",
               {resp_valid, resp_id, resp_grant}, 3'b111);
        chk(req_ready == 2'b01, "R3 back to master 0", req_ready, 2'b01);
        @(posedge clk);
        #1 req_valid = '0;
        chk(resp_valid && resp_id == 1'b0 && resp_grant, "R3 m0 second verdict",
            {resp_valid, resp_id, resp_grant}, 3'b101);
        @(posedge clk);
        #1 chk(resp_valid == 1'b0, "R4 single-cycle response", resp_valid, 0);
    endtask

    initial begin
        t_reset_state();
        t_base_legal();
        t_reject_sticky();
        t_take();
        t_release();
        t_not_trigger();
        t_bad_op();
        t_arbitration();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule